// File: doc/BRIEF.md
# Three-Phase Apparent Power and Energy Quantiser

This block turns per-phase RMS voltage and RMS current readings into arithmetic apparent power and then into a count of energy units. It serves three phases. On each accepted sample strobe it captures the RMS values and per-phase gain words of all phases. It then runs them through one shared multiplier, one phase per clock in the order A, B, C. Each phase's power is first scaled by a signed fractional gain and saturated. The result is published on a 24-bit instantaneous output for that phase.

Each phase integrates its power into a 56-bit accumulator. When the accumulator rises strictly above a shared 48-bit threshold, the threshold is taken off, the remainder stays, and that phase's 32-bit energy counter advances by one. Energy counters are read through a simple registered read port. A read can optionally clear the counter it returns. A unit of energy that lands in the same clock as such a clear is kept in the counter.

Top module: `apparent_energy`

## Requirements
- R1: While reset is high, and in the clock after it, every instantaneous output, every energy counter, `rd_data` and `rd_valid` read as zero.
- R2: With zero gain, a phase's instantaneous output equals floor(V × I / 2^24), where V and I are its unsigned 24-bit RMS inputs.
- R3: The gain word G of a phase is 24-bit two's complement. The output becomes floor(P × (2^23 + G) / 2^23), where P is the R2 value, so G = −2^23 gives zero and G = 2^22 gives 1.5 × P.
- R4: A scaled result above 2^24 − 1 is saturated to 2^24 − 1.
- R5: A strobe accepted at clock edge E updates phase A's output at E+1, phase B's at E+2 and phase C's at E+3. A phase's output does not change at any other time.
- R6: A strobe is ignored at the three edges that follow its acceptance (E+1 to E+3). Inputs presented with an ignored strobe never reach the outputs.
- R7: At its processing edge, a phase adds its new power to its accumulator. If the sum exceeds the threshold, the energy counter increments and the accumulator keeps the sum minus the threshold; otherwise the accumulator keeps the sum. A phase emits at most one unit per sample.
- R8: `rd_en` high at an edge makes `rd_valid` high for the next cycle. `rd_data` then shows the selected counter as it was before that edge, with `rd_sel` 0, 1, 2 selecting A, B, C and 3 returning zero. Without `rd_en`, `rd_valid` is low and `rd_data` holds.
- R9: With `rd_clr` also high, the selected counter becomes zero plus any unit emitted for that phase at the same edge. A clear with `rd_sel` = 3 changes no counter.
- R10: A sum exactly equal to the threshold emits no unit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| smp_stb | input | 1 | New RMS sample available |
| vrms_flat | input | 72 | RMS voltage, phase p in bits [24p+23:24p] |
| irms_flat | input | 72 | RMS current, phase p in bits [24p+23:24p] |
| gain_flat | input | 72 | Signed gain, phase p in bits [24p+23:24p] |
| thresh | input | 48 | Shared energy quantum threshold |
| rd_en | input | 1 | Read request |
| rd_sel | input | 2 | Counter select: 0 A, 1 B, 2 C, 3 none |
| rd_clr | input | 1 | Clear the selected counter with the read |
| inst_pwr_flat | output | 72 | Instantaneous apparent power, phase p in bits [24p+23:24p] |
| rd_valid | output | 1 | Read data valid |
| rd_data | output | 32 | Energy counter read value |

## Verification
The colliding pair is a read-with-clear of a phase's counter and an energy unit emitted by that same phase at the same edge. The bench provokes it by setting the threshold to zero, raising the strobe, and issuing a clearing read of phase A in the very next cycle, which lands on A's processing edge. It then expects the read to return the old count and a follow-up read to return exactly one. A cycle-level reference model also runs alongside a long random stretch of strobes and clearing reads, so the same collision recurs on every phase.

// File: rtl/ape_pkg.sv
package ape_pkg;
  localparam int unsigned APE_PHASES = 3;
  localparam int unsigned APE_RMS_W  = 24;
  localparam int unsigned APE_GAIN_W = 24;
  localparam int unsigned APE_PWR_W  = 24;
  localparam int unsigned APE_ACC_W  = 56;
  localparam int unsigned APE_THR_W  = 48;
  localparam int unsigned APE_EN_W   = 32;
endpackage

// File: rtl/ape_seq.sv
// Captures one sample set per accepted strobe and walks the phases in order.
module ape_seq #(
  parameter int NPH    = 3,
  parameter int RMS_W  = 24,
  parameter int GAIN_W = 24,
  parameter int IDX_W  = 2
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    smp_stb,
  input  logic [NPH*RMS_W-1:0]    vrms_flat,
  input  logic [NPH*RMS_W-1:0]    irms_flat,
  input  logic [NPH*GAIN_W-1:0]   gain_flat,
  output logic                    busy,
  output logic [IDX_W-1:0]        idx,
  output logic [RMS_W-1:0]        cur_v,
  output logic [RMS_W-1:0]        cur_i,
  output logic [GAIN_W-1:0]       cur_g
);
  localparam logic [IDX_W-1:0] LAST = IDX_W'(NPH - 1);

  logic [RMS_W-1:0]  v_q [NPH];
  logic [RMS_W-1:0]  i_q [NPH];
  logic [GAIN_W-1:0] g_q [NPH];
  logic              take;

  assign take = smp_stb && !busy;

  always_ff @(posedge clk) begin
    if (rst) begin
      busy <= 1'b0;
      idx  <= '0;
    end else if (busy) begin
      busy <= (idx != LAST);
      idx  <= (idx == LAST) ? '0 : idx + 1'b1;
    end else if (smp_stb) begin
      busy <= 1'b1;
      idx  <= '0;
    end
  end

  // Capture registers carry no reset so they map onto plain storage.
  for (genvar p = 0; p < NPH; p++) begin : g_cap
    always_ff @(posedge clk) begin
      if (take) begin
        v_q[p] <= vrms_flat[p*RMS_W +: RMS_W];
        i_q[p] <= irms_flat[p*RMS_W +: RMS_W];
        g_q[p] <= gain_flat[p*GAIN_W +: GAIN_W];
      end
    end
  end

  always_comb begin
    cur_v = '0;
    cur_i = '0;
    cur_g = '0;
    for (int p = 0; p < NPH; p++) begin
      if (idx == IDX_W'(p)) begin
        cur_v = v_q[p];
        cur_i = i_q[p];
        cur_g = g_q[p];
      end
    end
  end
endmodule

// File: rtl/ape_gain_mult.sv
// Shared datapath: V*I, fractional gain, truncation toward zero, saturation.
module ape_gain_mult #(
  parameter int RMS_W  = 24,
  parameter int GAIN_W = 24,
  parameter int PWR_W  = 24
) (
  input  logic [RMS_W-1:0]  v,
  input  logic [RMS_W-1:0]  i,
  input  logic [GAIN_W-1:0] g,
  output logic [PWR_W-1:0]  pwr
);
  localparam int PROD_W = 2 * RMS_W;
  localparam int SHIFT  = PROD_W - PWR_W;
  localparam int SCL_W  = PWR_W + GAIN_W;
  localparam int FRAC   = GAIN_W - 1;

  logic [PROD_W-1:0]      prod;
  logic [PWR_W-1:0]       raw;
  logic [GAIN_W-1:0]      fac;
  logic [SCL_W-1:0]       scl;
  logic [SCL_W-FRAC-1:0]  whole;
  logic                   unused_low;

  assign prod  = PROD_W'(v) * PROD_W'(i);
  assign raw   = prod[PROD_W-1:SHIFT];
  // 2^(GAIN_W-1) + G, formed by flipping the sign bit (offset binary, never negative).
  assign fac   = {~g[GAIN_W-1], g[GAIN_W-2:0]};
  assign scl   = SCL_W'(raw) * SCL_W'(fac);
  assign whole = scl[SCL_W-1:FRAC];
  assign pwr   = whole[PWR_W] ? {PWR_W{1'b1}} : whole[PWR_W-1:0];
  assign unused_low = ^{prod[SHIFT-1:0], scl[FRAC-1:0]};
endmodule

// File: rtl/ape_phase_acc.sv
// Per-phase power register, remainder-keeping accumulator and energy counter.
module ape_phase_acc #(
  parameter int PWR_W = 24,
  parameter int ACC_W = 56,
  parameter int THR_W = 48,
  parameter int EN_W  = 32
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             step,
  input  logic [PWR_W-1:0] pwr,
  input  logic [THR_W-1:0] thr,
  input  logic             clr,
  output logic [PWR_W-1:0] inst,
  output logic [EN_W-1:0]  energy
);
  logic [ACC_W-1:0] acc;
  logic [ACC_W:0]   sum;
  logic [ACC_W:0]   thr_x;
  logic             over;
  logic [EN_W-1:0]  base;

  assign thr_x = (ACC_W+1)'(thr);
  assign sum   = {1'b0, acc} + (ACC_W+1)'(pwr);
  assign over  = sum > thr_x;
  // A clear drops the old count but never a unit earned at the same edge.
  assign base  = clr ? '0 : energy;

  always_ff @(posedge clk) begin
    if (rst) begin
      inst   <= '0;
      acc    <= '0;
      energy <= '0;
    end else begin
      if (step) begin
        inst <= pwr;
        acc  <= over ? ACC_W'(sum - thr_x) : sum[ACC_W-1:0];
      end
      energy <= base + EN_W'(step && over);
    end
  end
endmodule

// File: rtl/apparent_energy.sv
module apparent_energy
  import ape_pkg::*;
#(
  parameter int NPH    = APE_PHASES,
  parameter int RMS_W  = APE_RMS_W,
  parameter int GAIN_W = APE_GAIN_W,
  parameter int PWR_W  = APE_PWR_W,
  parameter int ACC_W  = APE_ACC_W,
  parameter int THR_W  = APE_THR_W,
  parameter int EN_W   = APE_EN_W
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  smp_stb,
  input  logic [NPH*RMS_W-1:0]  vrms_flat,
  input  logic [NPH*RMS_W-1:0]  irms_flat,
  input  logic [NPH*GAIN_W-1:0] gain_flat,
  input  logic [THR_W-1:0]      thresh,
  input  logic                  rd_en,
  input  logic [$clog2(NPH+1)-1:0] rd_sel,
  input  logic                  rd_clr,
  output logic [NPH*PWR_W-1:0]  inst_pwr_flat,
  output logic                  rd_valid,
  output logic [EN_W-1:0]       rd_data
);
  localparam int IDX_W = $clog2(NPH);
  localparam int SEL_W = $clog2(NPH + 1);

  logic              seq_busy;
  logic [IDX_W-1:0]  seq_idx;
  logic [RMS_W-1:0]  cur_v;
  logic [RMS_W-1:0]  cur_i;
  logic [GAIN_W-1:0] cur_g;
  logic [PWR_W-1:0]  cur_pwr;
  logic [EN_W-1:0]   energy_arr [NPH];
  logic [EN_W-1:0]   rd_mux;

  ape_seq #(
    .NPH(NPH), .RMS_W(RMS_W), .GAIN_W(GAIN_W), .IDX_W(IDX_W)
  ) u_seq (
    .clk(clk), .rst(rst), .smp_stb(smp_stb),
    .vrms_flat(vrms_flat), .irms_flat(irms_flat), .gain_flat(gain_flat),
    .busy(seq_busy), .idx(seq_idx),
    .cur_v(cur_v), .cur_i(cur_i), .cur_g(cur_g)
  );

  ape_gain_mult #(
    .RMS_W(RMS_W), .GAIN_W(GAIN_W), .PWR_W(PWR_W)
  ) u_mult (
    .v(cur_v), .i(cur_i), .g(cur_g), .pwr(cur_pwr)
  );

  for (genvar p = 0; p < NPH; p++) begin : g_phase
    ape_phase_acc #(
      .PWR_W(PWR_W), .ACC_W(ACC_W), .THR_W(THR_W), .EN_W(EN_W)
    ) u_acc (
      .clk(clk),
      .rst(rst),
      .step(seq_busy && (seq_idx == IDX_W'(p))),
      .pwr(cur_pwr),
      .thr(thresh),
      .clr(rd_en && rd_clr && (rd_sel == SEL_W'(p))),
      .inst(inst_pwr_flat[p*PWR_W +: PWR_W]),
      .energy(energy_arr[p])
    );
  end

  always_comb begin
    rd_mux = '0;
    for (int p = 0; p < NPH; p++) begin
      if (rd_sel == SEL_W'(p)) rd_mux = energy_arr[p];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_valid <= 1'b0;
      rd_data  <= '0;
    end else begin
      rd_valid <= rd_en;
      if (rd_en) rd_data <= rd_mux;
    end
  end
endmodule

// File: rtl/ape_chk.sv
module ape_chk #(
  parameter int NPH   = 3,
  parameter int IDX_W = 2,
  parameter int SEL_W = 2,
  parameter int PWR_W = 24,
  parameter int EN_W  = 32
) (
  input logic             clk,
  input logic             rst,
  input logic             rd_en,
  input logic [SEL_W-1:0] rd_sel,
  input logic             rd_valid,
  input logic [EN_W-1:0]  rd_data,
  input logic             busy,
  input logic [IDX_W-1:0] idx,
  input logic [PWR_W-1:0] inst_a
);
  // R1
  rst_clears_chk: assert property (@(posedge clk)
    rst |=> (!rd_valid && rd_data == '0));

  // R8
  rd_valid_chk: assert property (@(posedge clk) disable iff (rst)
    rd_en |=> rd_valid);

  // R8
  rd_idle_chk: assert property (@(posedge clk) disable iff (rst)
    !rd_en |=> !rd_valid);

  // R8
  sel_none_chk: assert property (@(posedge clk) disable iff (rst)
    (rd_en && rd_sel >= SEL_W'(NPH)) |=> rd_data == '0);

  // R6
  busy_len_chk: assert property (@(posedge clk) disable iff (rst)
    (busy && idx == IDX_W'(NPH - 1)) |=> !busy);

  // R5
  a_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !(busy && idx == '0) |=> $stable(inst_a));
endmodule

bind apparent_energy ape_chk #(
  .NPH(NPH), .IDX_W($clog2(NPH)), .SEL_W($clog2(NPH + 1)),
  .PWR_W(PWR_W), .EN_W(EN_W)
) u_chk (
  .clk(clk), .rst(rst), .rd_en(rd_en), .rd_sel(rd_sel),
  .rd_valid(rd_valid), .rd_data(rd_data),
  .busy(seq_busy), .idx(seq_idx),
  .inst_a(inst_pwr_flat[PWR_W-1:0])
);

// File: tb/tb_apparent_energy.sv
module tb_apparent_energy;
  localparam int NPH = 3, RW = 24, GW = 24, PW = 24, TW = 48, EW = 32;

  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic               rst = 1'b1, smp_stb = 1'b0, rd_en = 1'b0, rd_clr = 1'b0;
  logic [1:0]         rd_sel = '0;
  logic [NPH*RW-1:0]  vrms = '0, irms = '0;
  logic [NPH*GW-1:0]  gain = '0;
  logic [TW-1:0]      thresh = '1;
  logic [NPH*PW-1:0]  inst;
  logic               rd_valid;
  logic [EW-1:0]      rd_data;

  apparent_energy dut (
    .clk(clk), .rst(rst), .smp_stb(smp_stb),
    .vrms_flat(vrms), .irms_flat(irms), .gain_flat(gain),
    .thresh(thresh), .rd_en(rd_en), .rd_sel(rd_sel), .rd_clr(rd_clr),
    .inst_pwr_flat(inst), .rd_valid(rd_valid), .rd_data(rd_data)
  );

  int checks = 0, errors = 0, cyc = 0;
  bit cmp_on = 0, done = 0;

  task automatic chk(string tag, longint act, longint exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic longint pw(logic [23:0] v, logic [23:0] i, logic [23:0] g);
    longint raw, fac, sc;
    raw = (longint'(v) * longint'(i)) >>> 24;
    fac = 64'sd8388608 + longint'($signed(g));
    sc  = (raw * fac) >>> 23;
    if (sc > 16777215) sc = 16777215;
    return sc;
  endfunction

  // Behavioural reference model, stepped on every rising edge.
  logic [23:0] mv [3], mi [3], mg [3];
  logic [55:0] macc [3];
  logic [31:0] men [3];
  longint      minst [3];
  bit          mbusy, mrdv;
  int          mcnt;
  logic [31:0] mrdd, eold;
  logic [56:0] msum;
  longint      mp;

  always @(posedge clk) begin
    if (rst) begin
      for (int p = 0; p < 3; p++) begin
        macc[p] = '0; men[p] = '0; minst[p] = 0;
      end
      mbusy = 0; mcnt = 0; mrdv = 0; mrdd = '0;
    end else begin
      eold = (rd_sel < 3) ? men[rd_sel] : 32'd0;
      mrdv = rd_en;
      if (rd_en) mrdd = eold;
      if (mbusy) begin
        mp = pw(mv[mcnt], mi[mcnt], mg[mcnt]);
        minst[mcnt] = mp;
        msum = {1'b0, macc[mcnt]} + 57'(mp);
        if (msum > {9'd0, thresh}) begin
          macc[mcnt] = 56'(msum - {9'd0, thresh});
          men[mcnt]  = men[mcnt] + 1;
        end else begin
          macc[mcnt] = msum[55:0];
        end
        mcnt++;
        if (mcnt == 3) begin mbusy = 0; mcnt = 0; end
      end else if (smp_stb) begin
        for (int p = 0; p < 3; p++) begin
          mv[p] = vrms[p*RW +: RW];
          mi[p] = irms[p*RW +: RW];
          mg[p] = gain[p*GW +: GW];
        end
        mbusy = 1; mcnt = 0;
      end
      if (rd_en && rd_clr && rd_sel < 3) men[rd_sel] = men[rd_sel] - eold;
    end
  end

  always @(negedge clk) begin
    if (cmp_on && !rst) begin
      for (int p = 0; p < 3; p++) chk("R3 model inst", longint'(inst[p*PW +: PW]), minst[p]);
      chk("R8 model valid", longint'(rd_valid), longint'(mrdv));
      chk("R8 model data", longint'(rd_data), longint'(mrdd));
    end
  end

  task automatic set_ph(int p, longint v, longint i, longint g);
    vrms[p*RW +: RW] = RW'(v);
    irms[p*RW +: RW] = RW'(i);
    gain[p*GW +: GW] = GW'(g);
  endtask

  task automatic set_all(longint v, longint i, longint g);
    for (int p = 0; p < 3; p++) set_ph(p, v, i, g);
  endtask

  task automatic fire();
    @(negedge clk); smp_stb = 1'b1;
    @(negedge clk); smp_stb = 1'b0;
    repeat (3) @(negedge clk);
  endtask

  task automatic rd(int sel, bit clr, output longint val);
    @(negedge clk); rd_en = 1'b1; rd_sel = 2'(sel); rd_clr = clr;
    @(negedge clk); rd_en = 1'b0; rd_clr = 1'b0;
    val = longint'(rd_data);
    chk("R8 valid after read", longint'(rd_valid), 1);
  endtask

  task automatic do_reset();
    @(negedge clk); rst = 1'b1;
    repeat (2) @(negedge clk);
    rst = 1'b0;
  endtask

  function automatic longint ph(int p);
    return longint'(inst[p*PW +: PW]);
  endfunction

  task automatic finish_run();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000 && !done) begin
      done = 1;
      checks++; errors++;
      $display("FAIL R5 watchdog actual=running expected=finished");
      finish_run();
    end
  end

  longint val;
  localparam longint HALF = 64'd8388608;
  localparam longint FULL = 64'd16777215;

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1: reset state
    for (int p = 0; p < 3; p++) chk("R1 inst after reset", ph(p), 0);
    chk("R1 rd_valid after reset", longint'(rd_valid), 0);
    chk("R1 rd_data after reset", longint'(rd_data), 0);
    cmp_on = 1;
    rd(0, 0, val); chk("R1 energy A after reset", val, 0);

    // R2: plain product
    set_all(1000000, 2000000, 0);
    fire();
    for (int p = 0; p < 3; p++) chk("R2 product", ph(p), 119209);

    // R3: gain scaling
    set_ph(0, HALF, HALF, 4194304);
    set_ph(1, HALF, HALF, -4194304);
    set_ph(2, HALF, HALF, -8388608);
    fire();
    chk("R3 gain +0.5", ph(0), 6291456);
    chk("R3 gain -0.5", ph(1), 2097152);
    chk("R3 gain -1", ph(2), 0);

    // R4: saturation
    set_ph(0, FULL, FULL, 8388607);
    set_ph(1, FULL, FULL, 0);
    set_ph(2, 0, FULL, 0);
    fire();
    chk("R4 saturated", ph(0), FULL);
    chk("R4 below limit", ph(1), 16777214);

    // R5: phase order
    set_all(HALF, HALF, 0);
    @(negedge clk); smp_stb = 1'b1;
    @(negedge clk); smp_stb = 1'b0;
    @(negedge clk);
    chk("R5 A first", ph(0), 4194304);
    chk("R5 B not yet", ph(1), 16777214);
    @(negedge clk);
    chk("R5 B second", ph(1), 4194304);
    chk("R5 C not yet", ph(2), 0);
    @(negedge clk);
    chk("R5 C third", ph(2), 4194304);

    // R6: strobes while busy are ignored
    set_all(1000000, 2000000, 0);
    @(negedge clk); smp_stb = 1'b1;
    @(negedge clk); set_all(HALF, HALF, 0);
    @(negedge clk); smp_stb = 1'b0;
    @(negedge clk); smp_stb = 1'b1;
    @(negedge clk); smp_stb = 1'b0;
    repeat (3) @(negedge clk);
    for (int p = 0; p < 3; p++) chk("R6 ignored strobe", ph(p), 119209);

    // R10: equality does not emit; R7: remainder carries
    do_reset();
    thresh = 48'd4194304;
    set_all(HALF, HALF, 0);
    fire();
    rd(0, 0, val); chk("R10 equal to threshold", val, 0);
    fire();
    rd(0, 0, val); chk("R7 second sample emits", val, 1);

    do_reset();
    thresh = 48'd10000000;
    repeat (5) fire();
    rd(1, 0, val); chk("R7 five samples two units", val, 2);
    rd(3, 0, val); chk("R8 select none", val, 0);
    rd(2, 0, val); chk("R8 read C", val, 2);

    // R9: clear colliding with a unit on the same edge
    thresh = '0;
    @(negedge clk); smp_stb = 1'b1;
    @(negedge clk); smp_stb = 1'b0; rd_en = 1'b1; rd_sel = 2'd0; rd_clr = 1'b1;
    @(negedge clk); rd_en = 1'b0; rd_clr = 1'b0;
    chk("R9 collision read old", longint'(rd_data), 2);
    repeat (3) @(negedge clk);
    rd(0, 0, val); chk("R9 collision keeps unit", val, 1);
    rd(3, 1, val); chk("R9 clear none returns zero", val, 0);
    rd(2, 0, val); chk("R9 clear none leaves C", val, 3);
    rd(1, 1, val); chk("R9 clear read B", val, 3);
    rd(1, 0, val); chk("R9 B cleared", val, 0);

    // Random stretch against the model
    for (int c = 0; c < 4000; c++) begin
      @(negedge clk);
      if (c % 500 == 0) thresh = TW'({$urandom % 32'h0400_0000}) + 48'd1;
      for (int p = 0; p < 3; p++) begin
        vrms[p*RW +: RW] = RW'($urandom);
        irms[p*RW +: RW] = RW'($urandom);
        gain[p*GW +: GW] = GW'($urandom);
      end
      smp_stb = ($urandom % 3) == 0;
      rd_en   = ($urandom % 2) == 0;
      rd_sel  = 2'($urandom);
      rd_clr  = ($urandom % 4) == 0;
    end
    @(negedge clk);
    smp_stb = 1'b0; rd_en = 1'b0; rd_clr = 1'b0;
    repeat (5) @(negedge clk);
    done = 1;
    finish_run();
  end
endmodule